// File: doc/BRIEF.md
# Aspect Ratio Decision Debouncer

This block turns a noisy per-field aspect classification into a stable identification result. An upstream measurement stage looks at the black bands above and below the picture and, once per field, presents a raw 2-bit class together with a one-cycle field strobe. The class is plain 4:3, 16:9 wide, or wide with subtitles. The debouncer adopts a new class only after that class has been seen on a long run of consecutive fields, so brief misjudgements never reach the display controller.

Firmware can skip the wait. It raises a bypass request and holds it for at least three fields. This opens a one-shot wait-free window in which the next differing valid class is adopted at once. A synchronous clear forces the result back to 4:3. A standard select sets the field rate to 60 or 50 fields per second, so the wait stays the same length in seconds. Two direct flags repeat the result for pins that only need to know wide or wide-with-subtitles.

Top module: `aspect_settle`

## Requirements
- R1: `result` encodes 00 for 4:3, 01 for 16:9 wide and 10 for wide with subtitles. It reads 00 after reset and never shows 11.
- R2: `wide_flag` is high exactly when `result` is 01, and `subt_flag` is high exactly when `result` is 10, in every mode.
- R3: With `rate_50`=0, a valid class that differs from `result` is adopted at the clock edge that samples its WAIT_SEC*60-th consecutive field strobe.
- R4: With `rate_50`=1, the run length for R3 is WAIT_SEC*50 field strobes.
- R5: The run count restarts when a valid raw class differs from the previous valid class (a first sighting counts as 1). It is cleared when the raw class equals `result`.
- R6: Raw code 11 on a strobed field is invalid. It neither restarts nor advances the run count, and it leaves `result` unchanged.
- R7: `force_narrow` sampled high sets `result` to 00 at that edge. It also clears the run count and closes the wait-free window.
- R8: The wait-free window opens at the third consecutive field strobe with `bypass_req` high. A request that is high for fewer strobed fields has no effect.
- R9: While the window is open, the first strobed field with a valid class that differs from `result` is adopted at that same edge, and the window closes.
- R10: The window closes when `bypass_req` goes low. It reopens only after `bypass_req` has fallen and then risen again for three strobed fields.
- R11: `result` changes only at edges where `field_stb` or `force_narrow` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| field_stb | input | 1 | One-cycle strobe, once per field |
| raw_cls | input | 2 | Raw class for this field (00, 01, 10; 11 invalid) |
| rate_50 | input | 1 | 1 = 50 fields/s standard, 0 = 60 fields/s |
| bypass_req | input | 1 | Request to skip the wait (level, qualified over fields) |
| force_narrow | input | 1 | Synchronous clear of the result to 4:3 |
| result | output | 2 | Stable identification code |
| wide_flag | output | 1 | High for 16:9 wide without subtitles |
| subt_flag | output | 1 | High for wide with subtitles |

## Verification
Every result is due one clock after the edge that samples the strobe, clear or request causing it: `result` is a register and the flags decode it without further delay. The bench drives inputs on the falling edge and steps its behavioural model on the rising edge. It compares `result` and both flags on the next falling edge, so each comparison falls one full cycle after its cause. Directed checks on run lengths are taken after the final strobe of a run and its idle cycles. The run lengths are 59 against 60 fields, and 49 against 50, with invalid fields interleaved.

// File: rtl/aspect_settle_pkg.sv
package aspect_settle_pkg;

    typedef enum logic [1:0] {
        CLS_NARROW = 2'b00,
        CLS_WIDE   = 2'b01,
        CLS_SUBT   = 2'b10,
        CLS_BAD    = 2'b11
    } cls_t;

    function automatic logic cls_valid(input cls_t c);
        return c != CLS_BAD;
    endfunction

endpackage

// File: rtl/aspect_inst_gate.sv
module aspect_inst_gate
#(
    parameter int INST_FIELDS = 3
)
(
    input  logic clk,
    input  logic rst,
    input  logic field_stb,
    input  logic bypass_req,
    output logic open_now
);
    localparam int IW = $clog2(INST_FIELDS + 1);

    logic [IW-1:0] icnt;

    // Fires once per request, on the strobe that completes the minimum width.
    assign open_now = field_stb & bypass_req & (icnt == IW'(INST_FIELDS - 1));

    always_ff @(posedge clk) begin
        if (rst || !bypass_req) begin
            icnt <= '0;
        end else if (field_stb && icnt < IW'(INST_FIELDS)) begin
            icnt <= icnt + 1'b1;
        end
    end

    // R8: a request seen on its first strobed field cannot open the window yet.
    assert_short_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        (field_stb && bypass_req && icnt == '0 && INST_FIELDS > 1) |-> !open_now);

endmodule

// File: rtl/aspect_persist.sv
module aspect_persist
    import aspect_settle_pkg::*;
#(
    parameter int CNT_W = 8
)
(
    input  logic             clk,
    input  logic             rst,
    input  logic             field_stb,
    input  cls_t             raw,
    input  cls_t             cur,
    input  logic [CNT_W-1:0] limit,
    input  logic             clear,
    output logic             adopt
);
    cls_t             cand;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cnt_inc;
    logic             seen;

    assign cnt_inc = {1'b0, cnt} + 1'b1;
    assign seen    = field_stb && cls_valid(raw);
    assign adopt   = seen && (raw != cur) && (raw == cand) && (cnt_inc >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt  <= '0;
            cand <= CLS_NARROW;
        end else if (seen) begin
            if (raw == cur) begin
                cnt  <= '0;
                cand <= raw;
            end else if (raw != cand) begin
                cnt  <= CNT_W'(1);
                cand <= raw;
            end else if (adopt) begin
                cnt  <= '0;
            end else begin
                cnt  <= cnt_inc[CNT_W-1:0];
            end
        end
    end

    // R6: an invalid strobed class leaves the run state untouched.
    assert_invalid_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (field_stb && raw == CLS_BAD && !clear) |=> ($stable(cnt) && $stable(cand)));

endmodule

// File: rtl/aspect_settle.sv
module aspect_settle
    import aspect_settle_pkg::*;
#(
    parameter int WAIT_SEC    = 2,
    parameter int FIELDS_60   = 60,
    parameter int FIELDS_50   = 50,
    parameter int INST_FIELDS = 3
)
(
    input  logic       clk,
    input  logic       rst,
    input  logic       field_stb,
    input  logic [1:0] raw_cls,
    input  logic       rate_50,
    input  logic       bypass_req,
    input  logic       force_narrow,
    output logic [1:0] result,
    output logic       wide_flag,
    output logic       subt_flag
);
    localparam int LIM_60 = WAIT_SEC * FIELDS_60;
    localparam int LIM_50 = WAIT_SEC * FIELDS_50;
    localparam int LIM_MX = (LIM_60 > LIM_50) ? LIM_60 : LIM_50;
    localparam int CNT_W  = $clog2(LIM_MX + 1);

    cls_t             raw;
    cls_t             res_q;
    logic             win_q;
    logic             open_now;
    logic             bypass_now;
    logic             jump;
    logic             adopt;
    logic [CNT_W-1:0] limit;

    assign raw   = cls_t'(raw_cls);
    assign limit = rate_50 ? CNT_W'(LIM_50) : CNT_W'(LIM_60);

    aspect_inst_gate #(.INST_FIELDS(INST_FIELDS)) u_gate (
        .clk        (clk),
        .rst        (rst),
        .field_stb  (field_stb),
        .bypass_req (bypass_req),
        .open_now   (open_now)
    );

    assign bypass_now = (win_q & bypass_req) | open_now;
    assign jump       = bypass_now && field_stb && cls_valid(raw) && (raw != res_q);

    aspect_persist #(.CNT_W(CNT_W)) u_persist (
        .clk       (clk),
        .rst       (rst),
        .field_stb (field_stb),
        .raw       (raw),
        .cur       (res_q),
        .limit     (limit),
        .clear     (force_narrow | jump),
        .adopt     (adopt)
    );

    always_ff @(posedge clk) begin
        if (rst || force_narrow) begin
            res_q <= CLS_NARROW;
            win_q <= 1'b0;
        end else if (field_stb) begin
            if (jump || adopt) begin
                res_q <= raw;
            end
            win_q <= jump ? 1'b0 : bypass_now;
        end else begin
            win_q <= win_q & bypass_req;
        end
    end

    assign result    = res_q;
    assign wide_flag = (res_q == CLS_WIDE);
    assign subt_flag = (res_q == CLS_SUBT);

    assert_code_legal_R1: assert property (@(posedge clk) disable iff (rst)
        result != 2'b11);

    assert_flags_excl_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wide_flag, subt_flag}));

    assert_force_narrow_R7: assert property (@(posedge clk) disable iff (rst)
        force_narrow |=> (result == 2'b00 && !win_q));

    assert_quiet_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!field_stb && !force_narrow) |=> $stable(result));

    assert_invalid_keep_R6: assert property (@(posedge clk) disable iff (rst)
        (field_stb && raw_cls == 2'b11 && !force_narrow) |=> $stable(result));

    assert_window_drop_R10: assert property (@(posedge clk) disable iff (rst)
        (!bypass_req && !field_stb) |=> !win_q);

endmodule

// File: tb/aspect_settle_tb.sv
module aspect_settle_tb;

    localparam int WAIT_SEC = 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       field_stb = 1'b0;
    logic [1:0] raw_cls = 2'b00;
    logic       rate_50 = 1'b0;
    logic       bypass_req = 1'b0;
    logic       force_narrow = 1'b0;
    logic [1:0] result;
    logic       wide_flag;
    logic       subt_flag;

    int    vectors = 0;
    int    errors  = 0;
    string cur_req = "R1";
    bit    finished = 0;

    // reference state
    int m_res = 0, m_cand = 0, m_cnt = 0, m_icnt = 0;
    bit m_win = 0;

    always #2 clk = ~clk;

    aspect_settle #(.WAIT_SEC(WAIT_SEC)) u_dut (
        .clk(clk), .rst(rst), .field_stb(field_stb), .raw_cls(raw_cls),
        .rate_50(rate_50), .bypass_req(bypass_req), .force_narrow(force_narrow),
        .result(result), .wide_flag(wide_flag), .subt_flag(subt_flag)
    );

    always @(posedge clk) begin
        int  lim;
        bit  open, byp;
        int  r;
        r   = raw_cls;
        lim = (rate_50 ? 50 : 60) * WAIT_SEC;
        if (rst) begin
            m_res = 0; m_cand = 0; m_cnt = 0; m_icnt = 0; m_win = 0;
        end else begin
            open = field_stb && bypass_req && (m_icnt == 2);
            if (!bypass_req) m_icnt = 0;
            else if (field_stb && m_icnt < 3) m_icnt = m_icnt + 1;
            if (force_narrow) begin
                m_res = 0; m_cand = 0; m_cnt = 0; m_win = 0;
            end else if (field_stb) begin
                byp = (m_win && bypass_req) || open;
                if (r != 3 && byp && r != m_res) begin
                    m_res = r; m_cnt = 0; m_cand = 0; m_win = 0;
                end else begin
                    m_win = byp;
                    if (r != 3) begin
                        if (r == m_res) begin
                            m_cnt = 0; m_cand = r;
                        end else if (r != m_cand) begin
                            m_cand = r; m_cnt = 1;
                        end else if (m_cnt + 1 >= lim) begin
                            m_res = r; m_cnt = 0;
                        end else begin
                            m_cnt = m_cnt + 1;
                        end
                    end
                end
            end else begin
                m_win = m_win && bypass_req;
            end
        end
    end

    // per-cycle comparison, one cycle after each cause
    always @(negedge clk) begin
        if (!rst && !finished) begin
            vectors++;
            if (result !== 2'(m_res)) begin
                errors++;
                $display("FAIL %s result actual=%0d expected=%0d", cur_req, result, m_res);
            end
            if (wide_flag !== (m_res == 1) || subt_flag !== (m_res == 2)) begin
                errors++;
                $display("FAIL R2 flags actual=%b%b expected=%b%b", wide_flag, subt_flag,
                         m_res == 1, m_res == 2);
            end
        end
    end

    task automatic field(input logic [1:0] r);
        @(negedge clk);
        raw_cls = r; field_stb = 1'b1;
        @(negedge clk);
        field_stb = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic fields(input logic [1:0] r, input int n);
        for (int i = 0; i < n; i++) field(r);
    endtask

    task automatic expect_res(input logic [1:0] exp, input string tag);
        vectors++;
        if (result !== exp) begin
            errors++;
            $display("FAIL %s directed actual=%0d expected=%0d", tag, result, exp);
        end
    endtask

    task automatic pulse_force();
        @(negedge clk); force_narrow = 1'b1;
        @(negedge clk); force_narrow = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_res(2'b00, "R1");

        cur_req = "R3";
        fields(2'b01, 59);
        expect_res(2'b00, "R3");
        field(2'b01);
        expect_res(2'b01, "R3");

        cur_req = "R5";
        fields(2'b10, 30);
        field(2'b00);
        fields(2'b10, 59);
        expect_res(2'b01, "R5");
        field(2'b10);
        expect_res(2'b10, "R5");

        cur_req = "R6";
        fields(2'b00, 40);
        fields(2'b11, 5);
        expect_res(2'b10, "R6");
        fields(2'b00, 19);
        expect_res(2'b10, "R6");
        field(2'b00);
        expect_res(2'b00, "R6");

        cur_req = "R4";
        rate_50 = 1'b1;
        fields(2'b01, 49);
        expect_res(2'b00, "R4");
        field(2'b01);
        expect_res(2'b01, "R4");

        cur_req = "R8";
        bypass_req = 1'b1;
        fields(2'b10, 2);
        bypass_req = 1'b0;
        field(2'b10);
        expect_res(2'b01, "R8");

        cur_req = "R9";
        @(negedge clk); bypass_req = 1'b1;
        fields(2'b10, 2);
        expect_res(2'b01, "R9");
        field(2'b10);
        expect_res(2'b10, "R9");
        fields(2'b00, 5);
        expect_res(2'b10, "R9");
        bypass_req = 1'b0;

        cur_req = "R10";
        @(negedge clk); bypass_req = 1'b1;
        fields(2'b10, 4);
        bypass_req = 1'b0;
        field(2'b01);
        expect_res(2'b10, "R10");
        @(negedge clk); bypass_req = 1'b1;
        fields(2'b01, 3);
        expect_res(2'b01, "R10");
        bypass_req = 1'b0;

        cur_req = "R7";
        pulse_force();
        expect_res(2'b00, "R7");
        @(negedge clk); bypass_req = 1'b1;
        fields(2'b00, 3);
        pulse_force();
        field(2'b10);
        expect_res(2'b00, "R7");
        bypass_req = 1'b0;

        cur_req = "R11";
        raw_cls = 2'b10;
        repeat (20) @(negedge clk);
        expect_res(2'b00, "R11");

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog %s actual=timeout expected=completion", cur_req);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule